// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Sequencer

This block walks the rows of a multiplexed liquid-crystal display and supplies the column pattern for the row being driven. The host picks how many rows the panel has (2, 4 or 8). Each falling edge of a slow frame-rate input moves the scan to the next row. The block gives the display memory the address of the current row and shows the word that comes back on the column outputs. It also drives a one-hot row-select vector and a drive-polarity flag. The polarity flips once per complete frame, so over time the pixels see no DC component.

A strobe input serves two purposes in a chain of drivers. While the strobe is high, the block blanks its outputs: every row-select bit and every column bit sits at the inactive level, 0. The strobe also arms a resynchronisation, and the next falling frame-rate edge restarts the scan at the first row with polarity at its initial value. Because all drivers in the chain share the strobe and the frame-rate line, they all start their frames together. The analog bias levels and the voltage switching are left to the pad ring. This block produces only the digital select, data and polarity signals.

Top module: `lcd_row_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `blank` is 1, `row_sel` and `col_out` are all zero, and `row_idx` and `polarity` are 0.
- R2: `mux_sel` gives the number of active rows: 0 selects 2 rows, 1 selects 4, and 2 or 3 select 8. An FR falling edge is `fr` sampled high at one clock edge and low at the next. The scan position (`ram_addr`) advances by one on that second edge. `row_idx`, `row_sel`, `polarity` and `col_out` show the new row one clock later.
- R3: An FR falling edge while the scan is at the last active row (index 1, 3 or 7) moves the scan back to row index 0, which is the first row.
- R4: `polarity` inverts on every wrap from the last active row to row 0 and holds its value on every other step.
- R5: A clock edge with `strobe` high arms a resynchronisation. The next FR falling edge sets the row to index 0 and `polarity` to 0. This includes a falling edge at the same clock edge. While `strobe` stays high, every FR falling edge repeats this restart. After the strobe falls, one more restart happens at the next FR falling edge, and normal stepping follows.
- R6: One clock after a clock edge that samples `strobe`, `blank` equals that sampled value. While `blank` is 1, `row_sel` and `col_out` are all zero.
- R7: While `blank` is 0, `row_sel` has exactly one bit set, at position `row_idx`. `col_out` equals the memory word for row `row_idx`, read from address `ram_addr` with a one-clock read latency. Rows at or beyond the active count are never selected.
- R8: Clock cycles without an FR falling edge leave the row and polarity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fr | input | 1 | Frame-rate clock, sampled on `clk` |
| mux_sel | input | 2 | Active row count: 0=2, 1=4, 2/3=8 |
| strobe | input | 1 | Blank and resynchronisation request |
| ram_addr | output | 3 | Display memory read address (current row) |
| ram_rdata | input | 40 | Display memory read data, one-clock latency |
| row_idx | output | 3 | Displayed row index (0 = first row) |
| row_sel | output | 8 | One-hot row select, zero while blanked |
| col_out | output | 40 | Column on/off pattern, zero while blanked |
| polarity | output | 1 | Drive polarity for the current frame |
| blank | output | 1 | Outputs forced inactive |

## Verification
On every cycle the assertions check the step rules of the scan position: an increment on a plain FR falling edge, a wrap with a polarity flip at the last row, a restart under a pending or live strobe, and no change without an edge. They also check that the row select is one-hot and that a sampled strobe blanks the next cycle. Only the bench scenarios can show that the whole sequence, taken over several frames at each row count, visits the right rows in order with the right memory words. The same holds for the polarity pattern across wraps and for what a short strobe pulse does, one that falls between FR edges.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int MAX_ROWS = 8;
    localparam int ROW_W    = $clog2(MAX_ROWS);
    localparam int COLS     = 40;

    typedef logic [ROW_W-1:0] row_t;
    typedef logic [COLS-1:0]  col_t;

    typedef enum logic [1:0] {
        MUX_2  = 2'd0,
        MUX_4  = 2'd1,
        MUX_8  = 2'd2,
        MUX_8B = 2'd3
    } mux_mode_e;

    typedef struct packed {
        row_t row;
        logic pol;
        logic pend;
    } scan_state_t;

    typedef struct packed {
        row_t row;
        logic pol;
        logic blank;
    } disp_state_t;

    function automatic row_t last_row(input mux_mode_e mode);
        row_t r;
        case (mode)
            MUX_2:   r = row_t'(1);
            MUX_4:   r = row_t'(3);
            default: r = row_t'(MAX_ROWS - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lrs_edge_detect.sv
module lrs_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_in;
    end

    assign fall = sig_q & ~sig_in;
endmodule

// File: rtl/lrs_scan_ctrl.sv
module lrs_scan_ctrl
    import lrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fall,
    input  logic        strobe,
    input  row_t        last,
    output scan_state_t state
);
    scan_state_t nxt;

    always_comb begin
        nxt = state;
        if (strobe) nxt.pend = 1'b1;
        if (fall) begin
            if (state.pend || strobe) begin
                nxt.row  = '0;
                nxt.pol  = 1'b0;
                nxt.pend = strobe;
            end else if (state.row >= last) begin
                nxt.row = '0;
                nxt.pol = ~state.pol;
            end else begin
                nxt.row = state.row + row_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end
endmodule

// File: rtl/lrs_out_stage.sv
module lrs_out_stage
    import lrs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  scan_state_t         scan,
    input  logic                strobe,
    input  col_t                rdata,
    output logic [ROW_W-1:0]    row_idx,
    output logic [MAX_ROWS-1:0] row_sel,
    output col_t                col_out,
    output logic                polarity,
    output logic                blank
);
    disp_state_t disp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_q.row   <= '0;
            disp_q.pol   <= 1'b0;
            disp_q.blank <= 1'b1;
        end else begin
            disp_q.row   <= scan.row;
            disp_q.pol   <= scan.pol;
            disp_q.blank <= strobe;
        end
    end

    for (genvar g = 0; g < MAX_ROWS; g++) begin : g_sel
        assign row_sel[g] = ~disp_q.blank && (disp_q.row == row_t'(g));
    end

    assign col_out  = disp_q.blank ? '0 : rdata;
    assign row_idx  = disp_q.row;
    assign polarity = disp_q.pol;
    assign blank    = disp_q.blank;
endmodule

// File: rtl/lcd_row_sequencer.sv
module lcd_row_sequencer
    import lrs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fr,
    input  logic [1:0]          mux_sel,
    input  logic                strobe,
    output logic [ROW_W-1:0]    ram_addr,
    input  logic [COLS-1:0]     ram_rdata,
    output logic [ROW_W-1:0]    row_idx,
    output logic [MAX_ROWS-1:0] row_sel,
    output logic [COLS-1:0]     col_out,
    output logic                polarity,
    output logic                blank
);
    logic        fall_evt;
    row_t        last;
    scan_state_t scan_q;

    assign last = last_row(mux_mode_e'(mux_sel));

    lrs_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (fr),
        .fall   (fall_evt)
    );

    lrs_scan_ctrl u_scan (
        .clk    (clk),
        .rst    (rst),
        .fall   (fall_evt),
        .strobe (strobe),
        .last   (last),
        .state  (scan_q)
    );

    assign ram_addr = scan_q.row;

    lrs_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .scan     (scan_q),
        .strobe   (strobe),
        .rdata    (ram_rdata),
        .row_idx  (row_idx),
        .row_sel  (row_sel),
        .col_out  (col_out),
        .polarity (polarity),
        .blank    (blank)
    );
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker
    import lrs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                strobe,
    input logic                fall,
    input logic                pend,
    input row_t                row_cnt,
    input logic                pol_cnt,
    input row_t                last,
    input logic [MAX_ROWS-1:0] row_sel,
    input logic                blank,
    input col_t                col_out
);
    // R2: plain step increments the row and keeps polarity
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (fall && !strobe && !pend && row_cnt < last) |=>
        ((row_cnt - $past(row_cnt)) == row_t'(1) && pol_cnt == $past(pol_cnt)));

    // R3 / R4: wrap to first row flips polarity
    a_r3_wrap_flip: assert property (@(posedge clk) disable iff (rst)
        (fall && !strobe && !pend && row_cnt >= last) |=>
        (row_cnt == '0 && pol_cnt != $past(pol_cnt)));

    // R5: restart on an edge under a live strobe
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        (fall && (strobe || pend)) |=> (row_cnt == '0 && !pol_cnt));

    // R6: sampled strobe blanks the next cycle
    a_r6_blank: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (blank && row_sel == '0 && col_out == '0));

    // R7: exactly one row selected when visible
    a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
        !blank |-> $countones(row_sel) == 1);

    // R8: nothing moves without an FR falling edge
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !fall |=> (row_cnt == $past(row_cnt) && pol_cnt == $past(pol_cnt)));
endmodule

bind lcd_row_sequencer lrs_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .fall    (fall_evt),
    .pend    (scan_q.pend),
    .row_cnt (scan_q.row),
    .pol_cnt (scan_q.pol),
    .last    (last),
    .row_sel (row_sel),
    .blank   (blank),
    .col_out (col_out)
);

// File: tb/lcd_row_sequencer_tb_top.sv
module lcd_row_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fr = 1'b0;
    logic [1:0]  mux_sel = 2'd0;
    logic        strobe = 1'b0;
    logic [2:0]  ram_addr;
    logic [39:0] ram_rdata;
    logic [2:0]  row_idx;
    logic [7:0]  row_sel;
    logic [39:0] col_out;
    logic        polarity;
    logic        blank;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [39:0] word_of(input int i);
        logic [7:0] b;
        b = 8'((i + 1) * 8'h13);
        return {b, ~b, b, ~b, b};
    endfunction

    always_ff @(posedge clk) ram_rdata <= word_of(int'(ram_addr));

    lcd_row_sequencer dut_i (
        .clk(clk), .rst(rst), .fr(fr), .mux_sel(mux_sel), .strobe(strobe),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata), .row_idx(row_idx),
        .row_sel(row_sel), .col_out(col_out), .polarity(polarity), .blank(blank)
    );

    typedef struct {
        logic [2:0]  row;
        logic        pol;
        logic        blk;
        logic [7:0]  sel;
        logic [39:0] col;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // reference model state
    int   m_row = 0;
    logic m_pol = 0;
    logic m_pend = 0;

    function automatic int rows_of(input logic [1:0] m);
        return (m == 2'd0) ? 2 : (m == 2'd1) ? 4 : 8;
    endfunction

    task automatic push(input string tag);
        exp_t e;
        e.row = 3'(m_row);
        e.pol = m_pol;
        e.blk = strobe;
        e.sel = strobe ? 8'h00 : 8'(1 << m_row);
        e.col = strobe ? 40'h0 : word_of(m_row);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check_one(input string tag, input logic [63:0] act,
                             input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: pop and compare after outputs settle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check_one(e.tag, 64'(row_idx),  64'(e.row), "row_idx");
                check_one(e.tag, 64'(polarity), 64'(e.pol), "polarity");
                check_one(e.tag, 64'(blank),    64'(e.blk), "blank");
                check_one(e.tag, 64'(row_sel),  64'(e.sel), "row_sel");
                check_one(e.tag, 64'(col_out),  64'(e.col), "col_out");
            end
        end
    end

    // driver: one FR period, model update, expected item
    task automatic fr_step(input string tag);
        @(negedge clk) fr = 1'b1;
        @(negedge clk) fr = 1'b0;
        if (m_pend || strobe) begin
            m_row = 0; m_pol = 0; m_pend = strobe;
        end else if (m_row >= rows_of(mux_sel) - 1) begin
            m_row = 0; m_pol = ~m_pol;
        end else begin
            m_row++;
        end
        @(negedge clk);
        @(negedge clk);
        push(tag);
    endtask

    task automatic set_strobe(input logic v, input string tag);
        @(negedge clk) strobe = v;
        if (v) m_pend = 1'b1;
        @(negedge clk);
        push(tag);
    endtask

    task automatic resync(input logic [1:0] m);
        set_strobe(1'b1, "R6");
        mux_sel = m;
        fr_step("R5");
        set_strobe(1'b0, "R6");
        fr_step("R5");
    endtask

    initial begin
        // R1: state during reset and just after release
        repeat (3) @(negedge clk);
        checks++;
        if (!(blank === 1'b1 && row_sel === 8'h00 && col_out === 40'h0 &&
              row_idx === 3'd0 && polarity === 1'b0)) begin
            errors++;
            $display("FAIL R1 actual blank=%b sel=%h idx=%0d pol=%b expected 1/00/0/0",
                     blank, row_sel, row_idx, polarity);
        end
        @(negedge clk) rst = 1'b0;
        checks++;
        if (blank !== 1'b1 || row_sel !== 8'h00) begin
            errors++;
            $display("FAIL R1 actual blank=%b sel=%h expected 1/00", blank, row_sel);
        end
        @(negedge clk);
        push("R7");

        // R2/R3/R4: 2-row mode over several frames
        for (int i = 0; i < 6; i++) fr_step("R3_R4_mux2");

        // R8: long hold of fr high, no change
        @(negedge clk) fr = 1'b1;
        repeat (6) @(negedge clk);
        push("R8");
        @(negedge clk) fr = 1'b0;
        if (m_row >= 1) begin m_row = 0; m_pol = ~m_pol; end else m_row++;
        @(negedge clk); @(negedge clk);
        push("R2");

        // 4-row mode
        resync(2'd1);
        for (int i = 0; i < 9; i++) fr_step("R3_R4_mux4");

        // 8-row mode
        resync(2'd2);
        for (int i = 0; i < 17; i++) fr_step("R3_R4_mux8");

        // short strobe mid-frame, no FR edge while high
        for (int i = 0; i < 2; i++) fr_step("R2");
        set_strobe(1'b1, "R6");
        set_strobe(1'b0, "R6");
        fr_step("R5_short");
        fr_step("R2");

        // strobe held over several FR edges
        set_strobe(1'b1, "R6");
        for (int i = 0; i < 3; i++) fr_step("R5_held");
        set_strobe(1'b0, "R6");
        fr_step("R5");
        fr_step("R2");

        // encoding 3 behaves as 8 rows
        resync(2'd3);
        for (int i = 0; i < 9; i++) fr_step("R2_mux3");

        repeat (4) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule